// File: doc/BRIEF.md
# USB Frame Interval Timer

This block keeps frame time for a full-speed USB host controller. It holds five registers: the frame interval, the remaining-time counter, the frame number, the periodic start point and the low-speed threshold. While the `run` input is high, each pulse on `bit_tick` (the 12 MHz bit-time enable) lowers the 14-bit remaining counter by one. When a tick finds the counter at zero, a frame boundary starts. The block signals end-of-frame and steps the frame number. It reloads the counter from the interval register, copies the interval's toggle bit into the remaining register, and then signals start-of-frame. Other blocks of the controller watch these pulses to schedule their work. This block does no descriptor handling of its own.

Software writes the registers one byte at a time. Each byte lane has its own mask of writable bits, and bits outside the mask stay zero. Reads return a whole 32-bit word, chosen by word index.

The sequencer has four states. HALT is the idle state while `run` is low. COUNT is the state in which the counter runs. EOF is a one-cycle state that marks the end of a frame and applies the reload. SOF is a one-cycle state that marks the start of the next frame. The transitions are:
- HALT→COUNT when `run` is high.
- COUNT→HALT when `run` is low.
- COUNT→EOF when a tick arrives with the counter at zero.
- EOF→SOF always.
- SOF→COUNT when `run` is high, otherwise SOF→HALT.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset every register reads zero, the state is HALT, and `eof_pulse`, `sof_pulse` and `fnum_msb_pulse` are low.
- R2: In COUNT with `run` high, each `bit_tick` lowers a nonzero remaining count (bits [13:0] of word 1) by one. The new value is readable on the cycle after the tick edge.
- R3: A tick that finds the remaining count at zero raises `eof_pulse` for exactly one cycle, on the cycle after the tick edge. `sof_pulse` is high for one cycle on the cycle after that.
- R4: The edge that ends EOF loads remaining [13:0] from interval [13:0] (word 0). The same edge sets remaining bit 31 to interval bit 31, whether that clears or sets it.
- R5: The same edge adds one to the 16-bit frame number (word 2). The value 0xFFFF wraps to 0x0000.
- R6: `fnum_msb_pulse` is high for one cycle in the cycle after bit 15 of the frame number changes, whether an increment or a write changed it.
- R7: Writes to word 1 follow per-lane masks. Byte address 4 keeps all bits, byte 5 keeps only 0x3F, byte 6 is ignored, and byte 7 keeps only 0x80.
- R8: Frame-number bytes 10 and 11 are ignored. Periodic start (word 3) byte 13 keeps 0x3F, and low-speed threshold (word 4) byte 17 keeps 0x0F. The upper two bytes of words 3 and 4 are ignored. Every byte of interval word 0 is writable. The byte address is word×4+lane.
- R9: While `run` is low, ticks change no register and raise no pulse.
- R10: A `bit_tick` that arrives during EOF or SOF is ignored. The reloaded count is not decremented by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables frame counting |
| bit_tick | input | 1 | One-cycle 12 MHz bit-time enable |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 5 | Byte address (word×4+lane) |
| wr_data | input | 8 | Write byte |
| rd_word | input | 3 | Read word index 0..4 |
| rd_data | output | 32 | Selected register word |
| eof_pulse | output | 1 | End-of-frame strobe |
| sof_pulse | output | 1 | Start-of-frame strobe |
| fnum_msb_pulse | output | 1 | Frame number bit 15 changed |

## Verification
The hardest case to reach is the frame-number wrap, which would take 65536 full frames if left to count on its own. The bench writes the frame number to 0xFFFF and sets the interval to zero. A single expiring tick then produces the wrap, the bit 15 pulse and the clearing of the toggle bit on one boundary. Ticks that land in the EOF and SOF cycles are reached by holding `bit_tick` high across the boundary. The bench then confirms that the reloaded count was not decremented.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int REM_W    = 14;
    localparam int FNUM_W   = 16;
    localparam int PSTART_W = 14;
    localparam int LSTH_W   = 12;
    localparam int TGL_BIT  = 31;

    localparam logic [2:0] W_IVAL   = 3'd0;
    localparam logic [2:0] W_REM    = 3'd1;
    localparam logic [2:0] W_FNUM   = 3'd2;
    localparam logic [2:0] W_PSTART = 3'd3;
    localparam logic [2:0] W_LSTH   = 3'd4;

    localparam logic [31:0] M_IVAL   = 32'hFFFF_FFFF;
    localparam logic [31:0] M_REM    = (32'h1 << TGL_BIT) | ((32'h1 << REM_W) - 32'h1);
    localparam logic [31:0] M_FNUM   = (32'h1 << FNUM_W) - 32'h1;
    localparam logic [31:0] M_PSTART = (32'h1 << PSTART_W) - 32'h1;
    localparam logic [31:0] M_LSTH   = (32'h1 << LSTH_W) - 32'h1;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EOF   = 2'd2,
        ST_SOF   = 2'd3
    } frm_state_e;

    function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                               input logic [1:0]  lane,
                                               input logic [7:0]  data,
                                               input logic [31:0] wmask);
        logic [31:0] m;
        m = (32'hFF << {lane, 3'b000}) & wmask;
        return (cur & ~m) | ({4{data}} & m);
    endfunction
endpackage

// File: rtl/frm_seq.sv
module frm_seq
    import frm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic rem_zero,
    output logic dec_en,
    output logic reload,
    output logic eof_o,
    output logic sof_o
);
    frm_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  state_nx = run ? ST_COUNT : ST_HALT;
            ST_COUNT: begin
                if (!run)                 state_nx = ST_HALT;
                else if (tick && rem_zero) state_nx = ST_EOF;
            end
            ST_EOF:   state_nx = ST_SOF;
            ST_SOF:   state_nx = run ? ST_COUNT : ST_HALT;
            default:  state_nx = ST_HALT;
        endcase
    end

    always_comb begin
        dec_en = (state == ST_COUNT) && run && tick && !rem_zero;
        reload = (state == ST_EOF);
        eof_o  = (state == ST_EOF);
        sof_o  = (state == ST_SOF);
    end

    assert_sof_after_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> (sof_o && !eof_o));
    assert_boundary_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && run && tick && rem_zero) |=> eof_o);
    assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof_o && sof_o));
endmodule

// File: rtl/frm_regs.sv
module frm_regs
    import frm_pkg::*;
#(
    parameter int ADDR_W = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic              reload,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        rd_word,
    output logic [31:0]       rd_data,
    output logic              rem_zero,
    output logic              msb_pulse
);
    localparam int PAD_REM = TGL_BIT - REM_W;

    logic [31:0]         ival_q;
    logic [REM_W-1:0]    rem_q;
    logic                tgl_q;
    logic [FNUM_W-1:0]   fnum_q;
    logic [PSTART_W-1:0] pstart_q;
    logic [LSTH_W-1:0]   lsth_q;
    logic                msb_prev_q;

    logic [2:0]  w_word;
    logic [1:0]  w_lane;
    logic        wr_ival, wr_rem, wr_fnum, wr_pstart, wr_lsth;
    logic [31:0] rem_img, rem_base, rem_nx, fnum_img, fnum_nx;
    logic [31:0] ival_img, pstart_img, lsth_img, ival_nx, pstart_nx, lsth_nx;

    assign w_word    = wr_addr[ADDR_W-1:2];
    assign w_lane    = wr_addr[1:0];
    assign wr_ival   = wr_en && (w_word == W_IVAL);
    assign wr_rem    = wr_en && (w_word == W_REM);
    assign wr_fnum   = wr_en && (w_word == W_FNUM);
    assign wr_pstart = wr_en && (w_word == W_PSTART);
    assign wr_lsth   = wr_en && (w_word == W_LSTH);

    assign rem_img    = {tgl_q, {PAD_REM{1'b0}}, rem_q};
    assign fnum_img   = {{(32-FNUM_W){1'b0}}, fnum_q};
    assign ival_img   = ival_q;
    assign pstart_img = {{(32-PSTART_W){1'b0}}, pstart_q};
    assign lsth_img   = {{(32-LSTH_W){1'b0}}, lsth_q};
    assign rem_zero   = (rem_q == '0);

    always_comb begin
        if (reload)      rem_base = {ival_q[TGL_BIT], {PAD_REM{1'b0}}, ival_q[REM_W-1:0]};
        else if (dec_en) rem_base = rem_img - 32'd1;
        else             rem_base = rem_img;
        rem_nx    = wr_rem ? lane_merge(rem_base, w_lane, wr_data, M_REM) : rem_base;
        fnum_nx   = reload ? fnum_img + 32'd1 : fnum_img;
        fnum_nx   = wr_fnum ? lane_merge(fnum_nx, w_lane, wr_data, M_FNUM) : fnum_nx;
        ival_nx   = wr_ival ? lane_merge(ival_img, w_lane, wr_data, M_IVAL) : ival_img;
        pstart_nx = wr_pstart ? lane_merge(pstart_img, w_lane, wr_data, M_PSTART) : pstart_img;
        lsth_nx   = wr_lsth ? lane_merge(lsth_img, w_lane, wr_data, M_LSTH) : lsth_img;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q     <= '0;
            rem_q      <= '0;
            tgl_q      <= 1'b0;
            fnum_q     <= '0;
            pstart_q   <= '0;
            lsth_q     <= '0;
            msb_prev_q <= 1'b0;
        end else begin
            ival_q     <= ival_nx;
            rem_q      <= rem_nx[REM_W-1:0];
            tgl_q      <= rem_nx[TGL_BIT];
            fnum_q     <= fnum_nx[FNUM_W-1:0];
            pstart_q   <= pstart_nx[PSTART_W-1:0];
            lsth_q     <= lsth_nx[LSTH_W-1:0];
            msb_prev_q <= fnum_q[FNUM_W-1];
        end
    end

    assign msb_pulse = fnum_q[FNUM_W-1] ^ msb_prev_q;

    always_comb begin
        case (rd_word)
            W_IVAL:   rd_data = ival_img;
            W_REM:    rd_data = rem_img;
            W_FNUM:   rd_data = fnum_img;
            W_PSTART: rd_data = pstart_img;
            W_LSTH:   rd_data = lsth_img;
            default:  rd_data = '0;
        endcase
    end

    assert_reload_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_rem && !wr_ival) |=>
            (rem_q == $past(ival_q[REM_W-1:0]) && tgl_q == $past(ival_q[TGL_BIT])));
    assert_fnum_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_fnum) |=> (fnum_q == $past(fnum_q) + FNUM_W'(1)));
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !wr_rem) |=> (rem_q == $past(rem_q) - REM_W'(1)));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en && !reload && !wr_rem) |=> $stable(rem_q));
    assert_wrap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_fnum && fnum_q[FNUM_W-2:0] == '1) |=> msb_pulse);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import frm_pkg::*;
#(
    parameter int ADDR_W = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        rd_word,
    output logic [31:0]       rd_data,
    output logic              eof_pulse,
    output logic              sof_pulse,
    output logic              fnum_msb_pulse
);
    logic dec_en, reload, rem_zero;

    frm_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (bit_tick),
        .rem_zero (rem_zero),
        .dec_en   (dec_en),
        .reload   (reload),
        .eof_o    (eof_pulse),
        .sof_o    (sof_pulse)
    );

    frm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_en    (dec_en),
        .reload    (reload),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .rem_zero  (rem_zero),
        .msb_pulse (fnum_msb_pulse)
    );

    assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !eof_pulse) |=> !eof_pulse);
endmodule

// File: tb/usb_frame_timer_test.sv
module usb_frame_timer_test;
    logic        clk = 1'b0;
    logic        rst_n, run, bit_tick, wr_en;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [2:0]  rd_word;
    logic [31:0] rd_data;
    logic        eof_pulse, sof_pulse, fnum_msb_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [4:0]  addr;
        logic [7:0]  data;
        logic [2:0]  word;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{5'h04, 8'hFF, 3'd1, 32'h0000_00FF},   // R7 lane 0 full
        '{5'h05, 8'hFF, 3'd1, 32'h0000_3FFF},   // R7 lane 1 0x3F
        '{5'h06, 8'hFF, 3'd1, 32'h0000_3FFF},   // R7 lane 2 ignored
        '{5'h07, 8'hFF, 3'd1, 32'h8000_3FFF},   // R7 lane 3 0x80
        '{5'h0A, 8'hFF, 3'd2, 32'h0000_0000},   // R8 fnum lane 2 ignored
        '{5'h08, 8'h34, 3'd2, 32'h0000_0034},   // R8
        '{5'h09, 8'h12, 3'd2, 32'h0000_1234},   // R8
        '{5'h0B, 8'hFF, 3'd2, 32'h0000_1234},   // R8 fnum lane 3 ignored
        '{5'h0D, 8'hFF, 3'd3, 32'h0000_3F00},   // R8 periodic start
        '{5'h0E, 8'hFF, 3'd3, 32'h0000_3F00},   // R8
        '{5'h11, 8'hFF, 3'd4, 32'h0000_0F00},   // R8 low-speed threshold
        '{5'h13, 8'hFF, 3'd4, 32'h0000_0F00},   // R8
        '{5'h03, 8'h80, 3'd0, 32'h8000_0000}    // R8 interval lane 3
    };

    usb_frame_timer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_word(rd_word), .rd_data(rd_data),
        .eof_pulse(eof_pulse), .sof_pulse(sof_pulse), .fnum_msb_pulse(fnum_msb_pulse)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] v);
        rd_word = w;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1;
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; run = 1'b0; bit_tick = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int w = 0; w < 5; w++) begin
            rd(3'(w), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 eof", {31'b0, eof_pulse}, 32'h0);
        chk("R1 sof", {31'b0, sof_pulse}, 32'h0);
        chk("R1 msb", {31'b0, fnum_msb_pulse}, 32'h0);

        // R7 / R8 write masks from the table
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].addr, TBL[i].data);
            rd(TBL[i].word, v);
            chk("R7/R8 mask", v, TBL[i].expv);
        end

        // R9 ticks while stopped
        tick1();
        tick1();
        rd(3'd1, v);
        chk("R9 hold", v, 32'h8000_3FFF);
        chk("R9 no eof", {31'b0, eof_pulse}, 32'h0);

        // set remaining = 3, interval = 0x80000005
        wr(5'h07, 8'h00);
        wr(5'h05, 8'h00);
        wr(5'h04, 8'h03);
        wr(5'h00, 8'h05);
        rd(3'd0, v);
        chk("R8 interval", v, 32'h8000_0005);

        run = 1'b1;
        repeat (2) @(negedge clk);
        tick1(); rd(3'd1, v); chk("R2 dec 2", v, 32'd2);
        tick1(); rd(3'd1, v); chk("R2 dec 1", v, 32'd1);
        tick1(); rd(3'd1, v); chk("R2 dec 0", v, 32'd0);

        // expiry; hold tick across EOF and SOF (R10)
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        chk("R3 eof", {31'b0, eof_pulse}, 32'h1);
        chk("R3 sof low", {31'b0, sof_pulse}, 32'h0);
        rd(3'd2, v); chk("R5 before", v, 32'h1234);
        @(negedge clk);
        chk("R3 sof", {31'b0, sof_pulse}, 32'h1);
        chk("R3 eof low", {31'b0, eof_pulse}, 32'h0);
        rd(3'd1, v); chk("R4 reload+toggle", v, 32'h8000_0005);
        rd(3'd2, v); chk("R5 inc", v, 32'h1235);
        @(negedge clk);
        bit_tick = 1'b0;
        rd(3'd1, v); chk("R10 ignored", v, 32'h8000_0005);
        tick1(); rd(3'd1, v); chk("R2 after reload", v, 32'h8000_0004);

        // R9 stop mid-frame
        run = 1'b0;
        @(negedge clk);
        tick1(); tick1();
        rd(3'd1, v); chk("R9 stopped", v, 32'h8000_0004);

        // R6 via write, R5 wrap
        wr(5'h09, 8'hFF);
        chk("R6 write flip", {31'b0, fnum_msb_pulse}, 32'h1);
        wr(5'h08, 8'hFF);
        chk("R6 no flip", {31'b0, fnum_msb_pulse}, 32'h0);
        wr(5'h03, 8'h00);
        wr(5'h00, 8'h00);
        wr(5'h04, 8'h00);
        wr(5'h07, 8'h00);
        rd(3'd1, v); chk("R7 cleared", v, 32'h0);
        wr(5'h07, 8'h80);
        run = 1'b1;
        repeat (2) @(negedge clk);
        tick1();
        chk("R3 eof wrap", {31'b0, eof_pulse}, 32'h1);
        @(negedge clk);
        rd(3'd2, v); chk("R5 wrap", v, 32'h0);
        chk("R6 wrap pulse", {31'b0, fnum_msb_pulse}, 32'h1);
        rd(3'd1, v); chk("R4 toggle cleared", v, 32'h0);
        @(negedge clk);
        chk("R6 one cycle", {31'b0, fnum_msb_pulse}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule